// File: doc/BRIEF.md
# Edge/Level Interrupt Handler Bank

This block gathers thirty-two active-high interrupt requests and presents them to a processor as two outputs: a normal interrupt line and a fast interrupt line. Each request line is configured either as edge-sensed, where a pending flag is latched on a new assertion and held until software removes it, or as level-sensed, where the pending flag follows the request. Each line also has a 5-bit priority and a class bit that routes it to the normal or the fast output.

For each class, an arbiter picks the winning unmasked pending line. A smaller priority value wins. When priorities are equal, the higher line number wins. The arbiter latches the winner's number as a code and raises that class's output. The output and the code then stay frozen until software writes the control register to re-arm the class. Reading a code register returns the latched number and acknowledges that line if it is edge-sensed. Software can also raise a line by writing a set-request register, which acts on the lowest set bit only.

The register port is a 32-bit, single-cycle bus with byte addresses. Write data takes effect at the clock edge. Read data is registered and appears on the cycle after the request.

Top module: `irq_bank_top`

## Requirements
- R1: After reset, pending reads 0 and the mask reads 0xFFFFFFFF. Every line configuration word reads 0, meaning edge-sensed, normal class and priority 0. Both outputs are low, and both code registers and the control register (0x18) read 0.
- R2: The configuration word of line n sits at 0x1C + 4n. Bit 0 selects the fast class (1) or the normal class (0). Bit 1 selects level (1) or edge (0) sensing. Bits 6:2 hold the priority. A read returns these seven bits with all upper bits 0.
- R3: On an edge-sensed line, the pending bit is set when the request goes from inactive to active. It stays set after the request drops.
- R4: On a level-sensed line, the pending bit is set whenever the request is active. It is cleared when the request drops.
- R5: Pending reads at 0x00. A write there ANDs the pending bits with the data, except that a level-sensed line whose request is still active keeps its bit.
- R6: The mask at 0x04 is read/write. A mask bit of 1 keeps the line out of arbitration even while its pending bit is set.
- R7: When a class is armed and has at least one unmasked pending line, the winner is latched as the code and the output rises one cycle after the pending bit becomes visible. The winner is the line with the smallest priority value, with ties going to the highest line number.
- R8: While a class output is high, its code and the output level do not change, even when new lines become pending.
- R9: Writing the control register at 0x18 re-arms classes. Bit 0 re-arms the normal class and bit 1 the fast class. A re-armed output is low in the cycle after the write, and arbitration resumes in the following cycle.
- R10: Reading 0x10 (normal) or 0x14 (fast) returns the latched code. If that line is edge-sensed, the read also clears its pending bit. Level-sensed lines are unaffected.
- R11: A write to 0x9C raises only the lowest-numbered set bit, as a new assertion of that line. A write of zero has no effect.
- R12: Writes to 0x10 and 0x14 are ignored. Reads of unmapped offsets return 0.
- R13: If a code read acknowledges an edge-sensed line in the same cycle as a new edge on that line, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 32 | Request lines, active high |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 1 | Normal-class interrupt to the processor |
| fiq_out | output | 1 | Fast-class interrupt to the processor |

## Verification
A code read both reports a line and may clear its pending bit, so it can coincide with a fresh rising edge on the same line. The bench provokes this by driving the acknowledging read and the new request in one cycle. It then expects the pending register still to show the line, while a second acknowledge with no new edge does clear it. A re-arm also competes with lines that are already pending. The bench requires the output to drop for exactly one cycle and then rise with the next winner, in the priority order set for those lines.

// File: rtl/irq_bank_pkg.sv
// Package: irq_bank_pkg
// Shared sizes and register offsets for the interrupt handler bank.
// Assumes a 32-bit register bus and byte addressing.
package irq_bank_pkg;
    localparam int IB_LINES  = 32;
    localparam int IB_PRIO_W = 5;
    localparam int IB_ID_W   = $clog2(IB_LINES);
    localparam int IB_DATA_W = 32;
    localparam int IB_ADDR_W = 8;
    localparam int IB_CLASSES = 2;   // 0 = normal, 1 = fast

    localparam logic [IB_ADDR_W-1:0] OFS_PEND     = 8'h00;
    localparam logic [IB_ADDR_W-1:0] OFS_MASK     = 8'h04;
    localparam logic [IB_ADDR_W-1:0] OFS_CODE_IRQ = 8'h10;
    localparam logic [IB_ADDR_W-1:0] OFS_CODE_FIQ = 8'h14;
    localparam logic [IB_ADDR_W-1:0] OFS_CTRL     = 8'h18;
    localparam logic [IB_ADDR_W-1:0] OFS_CFG_BASE = 8'h1C;
    localparam logic [IB_ADDR_W-1:0] OFS_SWSET    = 8'h9C;
endpackage

// File: rtl/irq_line_sense.sv
// Module: irq_line_sense
// Holds the pending bits of all lines. Detects request edges against a
// registered copy of the pins, applies edge or level sensing per line,
// and merges software clears, acknowledges and injections.
// Assumes: sets take priority over clears in the same cycle.
module irq_line_sense #(
    parameter int LINES = irq_bank_pkg::IB_LINES,
    parameter int ID_W  = irq_bank_pkg::IB_ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] sense,      // 1 = level
    input  logic             clr_wr,
    input  logic [LINES-1:0] clr_data,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_id,
    input  logic             inj_valid,
    input  logic [ID_W-1:0]  inj_id,
    output logic [LINES-1:0] pend
);
    logic [LINES-1:0] in_q;
    logic [LINES-1:0] rise, fall, edg, inj_vec, ack_vec, set_vec, clr_vec;

    // Decode events and form the set and clear vectors.
    always_comb begin
        edg     = ~sense;
        rise    = irq_in & ~in_q;
        fall    = ~irq_in & in_q;
        inj_vec = inj_valid ? (LINES'(1) << inj_id) : '0;
        ack_vec = ack_valid ? (LINES'(1) << ack_id) : '0;
        set_vec = (edg & rise) | (sense & irq_in) | (inj_vec & (sense | ~in_q));
        clr_vec = (sense & fall) | (edg & ack_vec);
        if (clr_wr) begin
            clr_vec = clr_vec | ~(clr_data | (sense & irq_in));
        end
    end

    // Register pin history and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
            pend <= '0;
        end else begin
            in_q <= irq_in;
            pend <= (pend & ~clr_vec) | set_vec;
        end
    end

    p_edge_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~sense & irq_in & ~in_q)) |=>
        ((pend & $past(~sense & irq_in & ~in_q)) == $past(~sense & irq_in & ~in_q)));

    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sense & irq_in)) |=>
        ((pend & $past(sense & irq_in)) == $past(sense & irq_in)));

    p_level_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(sense & ~irq_in & in_q)) && !inj_valid) |=>
        ((pend & $past(sense & ~irq_in & in_q)) == '0));
endmodule

// File: rtl/irq_sorter.sv
// Module: irq_sorter
// Combinational winner search over candidate lines: smallest priority value
// wins, and equal priorities resolve toward the higher line number.
// Assumes: candidates are already masked and split by class.
module irq_sorter #(
    parameter int LINES  = irq_bank_pkg::IB_LINES,
    parameter int PRIO_W = irq_bank_pkg::IB_PRIO_W,
    parameter int ID_W   = irq_bank_pkg::IB_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  cand,
    input  logic [PRIO_W-1:0] prio [LINES],
    output logic              any,
    output logic [ID_W-1:0]   win_id
);
    logic [PRIO_W-1:0] best;

    // Ascending scan; "<=" lets a later equal-priority line take over.
    always_comb begin
        any    = 1'b0;
        best   = '0;
        win_id = '0;
        for (int i = 0; i < LINES; i++) begin
            if (cand[i] && (!any || prio[i] <= best)) begin
                any    = 1'b1;
                best   = prio[i];
                win_id = ID_W'(i);
            end
        end
    end

    p_win_is_cand_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> cand[win_id]);

    p_any_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any == (|cand));
endmodule

// File: rtl/irq_agree.sv
// Module: irq_agree
// One class's agreement latch. When armed and a winner exists, it captures
// the winner code and raises the output, then freezes both until re-armed.
// Assumes: a re-arm in the same cycle as a candidate defers the capture.
module irq_agree #(
    parameter int ID_W = irq_bank_pkg::IB_ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any,
    input  logic [ID_W-1:0] win_id,
    input  logic            rearm,
    output logic            out,
    output logic [ID_W-1:0] code
);
    logic armed;

    // Capture on the first winner while armed; a re-arm drops the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            out   <= 1'b0;
            code  <= '0;
        end else if (rearm) begin
            armed <= 1'b1;
            out   <= 1'b0;
        end else if (armed && any) begin
            armed <= 1'b0;
            out   <= 1'b1;
            code  <= win_id;
        end
    end

    p_rearm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !out);

    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out && !rearm) |=> (out && $stable(code)));

    p_rise_needs_cand_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out) |-> $past(any));
endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs
// Register decode: line configuration, mask, read mux and the command
// strobes that drive the pending logic and the agreement latches.
// Assumes: one access per cycle, read data registered.
module irq_regs #(
    parameter int LINES  = irq_bank_pkg::IB_LINES,
    parameter int PRIO_W = irq_bank_pkg::IB_PRIO_W,
    parameter int ID_W   = irq_bank_pkg::IB_ID_W,
    parameter int DATA_W = irq_bank_pkg::IB_DATA_W,
    parameter int ADDR_W = irq_bank_pkg::IB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  pend,
    input  logic [ID_W-1:0]   code_irq,
    input  logic [ID_W-1:0]   code_fiq,
    output logic [LINES-1:0]  mask,
    output logic [LINES-1:0]  fiq_sel,
    output logic [LINES-1:0]  sense,
    output logic [PRIO_W-1:0] prio [LINES],
    output logic              clr_wr,
    output logic [LINES-1:0]  clr_data,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              inj_valid,
    output logic [ID_W-1:0]   inj_id,
    output logic [1:0]        rearm
);
    import irq_bank_pkg::*;

    logic              wr, rd, cfg_hit;
    logic [ADDR_W-1:0] cfg_off;
    logic [ID_W-1:0]   cfg_idx;
    logic [DATA_W-1:0] rd_mux;

    // Address decode for the configuration window and command strobes.
    always_comb begin
        wr        = bus_valid & bus_write;
        rd        = bus_valid & ~bus_write;
        cfg_off   = bus_addr - OFS_CFG_BASE;
        cfg_hit   = (bus_addr >= OFS_CFG_BASE) && (cfg_off[1:0] == 2'b00) &&
                    (int'(cfg_off[ADDR_W-1:2]) < LINES);
        cfg_idx   = cfg_off[2 +: ID_W];
        clr_wr    = wr && (bus_addr == OFS_PEND);
        clr_data  = bus_wdata[LINES-1:0];
        ack_valid = rd && ((bus_addr == OFS_CODE_IRQ) || (bus_addr == OFS_CODE_FIQ));
        ack_id    = (bus_addr == OFS_CODE_FIQ) ? code_fiq : code_irq;
        rearm     = (wr && (bus_addr == OFS_CTRL)) ? bus_wdata[1:0] : 2'b00;
        inj_valid = wr && (bus_addr == OFS_SWSET) && (|bus_wdata[LINES-1:0]);
    end

    // Lowest set bit of the injection word.
    always_comb begin
        inj_id = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (bus_wdata[i]) inj_id = ID_W'(i);
        end
    end

    // Read multiplexer; unlisted offsets return zero.
    always_comb begin
        case (bus_addr)
            OFS_PEND:     rd_mux = DATA_W'(pend);
            OFS_MASK:     rd_mux = DATA_W'(mask);
            OFS_CODE_IRQ: rd_mux = DATA_W'(code_irq);
            OFS_CODE_FIQ: rd_mux = DATA_W'(code_fiq);
            default:      rd_mux = cfg_hit ?
                              DATA_W'({prio[cfg_idx], sense[cfg_idx], fiq_sel[cfg_idx]}) : '0;
        endcase
    end

    // Mask and per-line configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '1;
            fiq_sel <= '0;
            sense   <= '0;
            for (int i = 0; i < LINES; i++) prio[i] <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_MASK) mask <= bus_wdata[LINES-1:0];
            if (cfg_hit) begin
                fiq_sel[cfg_idx] <= bus_wdata[0];
                sense[cfg_idx]   <= bus_wdata[1];
                prio[cfg_idx]    <= bus_wdata[2 +: PRIO_W];
            end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    p_ctrl_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_CTRL) |=> (bus_rdata == '0));

    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_MASK) |=> (mask == $past(bus_wdata[LINES-1:0])));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_SWSET) |=> (bus_rdata == '0));
endmodule

// File: rtl/irq_bank_top.sv
// Module: irq_bank_top
// Top of the 32-line interrupt handler bank: register decode, pending
// state, and one sorter plus agreement latch per class (normal, fast).
// Assumes a synchronous active-low reset and a single clock.
module irq_bank_top #(
    parameter int LINES  = irq_bank_pkg::IB_LINES,
    parameter int PRIO_W = irq_bank_pkg::IB_PRIO_W,
    parameter int DATA_W = irq_bank_pkg::IB_DATA_W,
    parameter int ADDR_W = irq_bank_pkg::IB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_req,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              fiq_out
);
    localparam int ID_W    = $clog2(LINES);
    localparam int CLASSES = irq_bank_pkg::IB_CLASSES;

    logic [LINES-1:0]  pend, mask, fiq_sel, sense, clr_data;
    logic [PRIO_W-1:0] prio [LINES];
    logic              clr_wr, ack_valid, inj_valid;
    logic [ID_W-1:0]   ack_id, inj_id;
    logic [1:0]        rearm;
    logic              cls_out  [CLASSES];
    logic [ID_W-1:0]   cls_code [CLASSES];

    irq_regs #(.LINES(LINES), .PRIO_W(PRIO_W), .ID_W(ID_W),
               .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(pend), .code_irq(cls_code[0]), .code_fiq(cls_code[1]),
        .mask(mask), .fiq_sel(fiq_sel), .sense(sense), .prio(prio),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .inj_valid(inj_valid), .inj_id(inj_id), .rearm(rearm)
    );

    irq_line_sense #(.LINES(LINES), .ID_W(ID_W)) u_sense (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_req), .sense(sense),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .inj_valid(inj_valid), .inj_id(inj_id), .pend(pend)
    );

    for (genvar c = 0; c < CLASSES; c++) begin : g_class
        logic [LINES-1:0] cand;
        logic             any;
        logic [ID_W-1:0]  win_id;

        // Unmasked pending lines routed to this class.
        always_comb cand = pend & ~mask & ((c == 1) ? fiq_sel : ~fiq_sel);

        irq_sorter #(.LINES(LINES), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sort (
            .clk(clk), .rst_n(rst_n), .cand(cand), .prio(prio),
            .any(any), .win_id(win_id)
        );

        irq_agree #(.ID_W(ID_W)) u_agree (
            .clk(clk), .rst_n(rst_n), .any(any), .win_id(win_id),
            .rearm(rearm[c]), .out(cls_out[c]), .code(cls_code[c])
        );
    end

    assign irq_out = cls_out[0];
    assign fiq_out = cls_out[1];
endmodule

// File: tb/irq_bank_top_tb.sv
module irq_bank_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [31:0] d;

    irq_bank_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cfg_addr(int n);
        return 8'h1C + 8'(4 * n);
    endfunction

    task automatic bus_wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        @(negedge clk);
        irq_req = '0;
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_wr(8'h18, 32'h3);
        bus_wr(8'h00, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 irq_out", {31'b0, irq_out}, 0);
        check("R1 fiq_out", {31'b0, fiq_out}, 0);
        bus_rd(8'h00, d); check("R1 pending", d, 0);
        bus_rd(8'h04, d); check("R1 mask", d, 32'hFFFF_FFFF);
        bus_rd(cfg_addr(5), d); check("R1 cfg line5", d, 0);
        bus_rd(8'h18, d); check("R1/R9 control reads 0", d, 0);
        bus_rd(8'h14, d); check("R1 fast code", d, 0);
    endtask

    task automatic t_cfg_layout();
        bus_wr(cfg_addr(7), 32'hFFFF_FFFF);
        bus_rd(cfg_addr(7), d); check("R2 cfg all ones", d, 32'h7F);
        bus_wr(cfg_addr(3), 32'h5A);
        bus_rd(cfg_addr(3), d); check("R2 cfg pattern", d, 32'h5A);
        bus_wr(cfg_addr(7), 0);
        bus_wr(cfg_addr(3), 0);
    endtask

    task automatic t_edge();
        quiesce();
        @(negedge clk) irq_req[4] = 1'b1;
        idle(2);
        bus_rd(8'h00, d); check("R3 edge latched", d, 32'h10);
        @(negedge clk) irq_req[4] = 1'b0;
        idle(2);
        bus_rd(8'h00, d); check("R3 edge held after drop", d, 32'h10);
        bus_wr(8'h00, 0);
        bus_rd(8'h00, d); check("R5 clear edge line", d, 0);
    endtask

    task automatic t_level();
        quiesce();
        bus_wr(cfg_addr(9), 32'h2);
        @(negedge clk) irq_req[9] = 1'b1;
        idle(2);
        bus_rd(8'h00, d); check("R4 level set", d, 32'h200);
        bus_wr(8'h00, 0);
        bus_rd(8'h00, d); check("R5 active level kept", d, 32'h200);
        @(negedge clk) irq_req[9] = 1'b0;
        idle(2);
        bus_rd(8'h00, d); check("R4 level dropped", d, 0);
    endtask

    task automatic t_arbitrate();
        quiesce();
        bus_wr(cfg_addr(2), 32'h0C);
        bus_wr(cfg_addr(6), 32'h04);
        bus_wr(cfg_addr(20), 32'h04);
        bus_wr(8'h04, ~32'h0010_0044);
        @(negedge clk) irq_req = 32'h0010_0044;
        @(negedge clk);
        check("R7 not yet raised", {31'b0, irq_out}, 0);
        @(negedge clk);
        check("R7 raised after one cycle", {31'b0, irq_out}, 1);
        @(negedge clk) irq_req = '0;
        bus_rd(8'h10, d); check("R7 tie goes to higher line", d, 20);
        bus_rd(8'h00, d); check("R10 edge ack cleared", d, 32'h44);
        bus_rd(8'h10, d); check("R8 code held", d, 20);
        check("R8 output held", {31'b0, irq_out}, 1);
        bus_wr(8'h18, 32'h1);
        check("R9 output dropped", {31'b0, irq_out}, 0);
        bus_rd(8'h10, d); check("R7 lower value wins", d, 6);
        check("R9 rearmed raise", {31'b0, irq_out}, 1);
        bus_wr(8'h18, 32'h1);
        bus_rd(8'h10, d); check("R7 last winner", d, 2);
        bus_wr(8'h18, 32'h1);
        idle(3);
        check("R9 nothing left", {31'b0, irq_out}, 0);
        bus_wr(cfg_addr(2), 0);
        bus_wr(cfg_addr(6), 0);
        bus_wr(cfg_addr(20), 0);
    endtask

    task automatic t_mask();
        quiesce();
        @(negedge clk) irq_req[11] = 1'b1;
        idle(4);
        check("R6 masked stays low", {31'b0, irq_out}, 0);
        bus_wr(8'h04, ~32'h800);
        idle(1);
        check("R6 unmask raises", {31'b0, irq_out}, 1);
        bus_rd(8'h04, d); check("R6 mask readback", d, 32'hFFFF_F7FF);
        bus_rd(8'h10, d); check("R6 code", d, 11);
        bus_wr(8'h10, 32'h1F);
        bus_wr(8'h14, 32'h1F);
        bus_rd(8'h10, d); check("R12 code write ignored", d, 11);
        bus_rd(8'h08, d); check("R12 unmapped 0x08", d, 0);
        bus_rd(8'hA0, d); check("R12 unmapped 0xA0", d, 0);
        bus_rd(8'h9C, d); check("R12 set register reads 0", d, 0);
    endtask

    task automatic t_fast();
        quiesce();
        bus_wr(cfg_addr(13), 32'h1);
        bus_wr(8'h04, ~32'h2000);
        @(negedge clk) irq_req[13] = 1'b1;
        idle(3);
        check("R7 fast raised", {31'b0, fiq_out}, 1);
        check("R7 normal quiet", {31'b0, irq_out}, 0);
        bus_rd(8'h14, d); check("R10 fast code", d, 13);
        bus_wr(8'h18, 32'h2);
        check("R9 fast dropped", {31'b0, fiq_out}, 0);
        idle(3);
        check("R10 fast acked stays low", {31'b0, fiq_out}, 0);
        bus_wr(cfg_addr(13), 0);
    endtask

    task automatic t_inject();
        quiesce();
        bus_wr(8'h9C, 32'h0000_0A00);
        bus_rd(8'h00, d); check("R11 lowest bit only", d, 32'h200);
        bus_wr(8'h00, 0);
        bus_rd(8'h00, d); check("R5 inactive level cleared", d, 0);
        bus_wr(8'h9C, 32'h8000_0000);
        bus_wr(8'h9C, 32'h0);
        bus_rd(8'h00, d); check("R11 zero write no effect", d, 32'h8000_0000);
        bus_wr(cfg_addr(9), 0);
    endtask

    task automatic t_collide();
        quiesce();
        bus_wr(8'h04, ~32'h4000);
        @(negedge clk) irq_req[14] = 1'b1;
        idle(3);
        check("R7 line14 raised", {31'b0, irq_out}, 1);
        @(negedge clk) irq_req[14] = 1'b0;
        idle(2);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h10; irq_req[14] = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R10 code during collide", bus_rdata, 14);
        bus_rd(8'h00, d); check("R13 new edge survives ack", d, 32'h4000);
        bus_rd(8'h10, d);
        bus_rd(8'h00, d); check("R10 plain ack clears", d, 0);
        quiesce();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_cfg_layout();
        t_edge();
        t_level();
        t_arbitrate();
        t_mask();
        t_fast();
        t_inject();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule